// File: doc/BRIEF.md
# Dual-Copy Configuration Register Bank

This block holds six byte-wide control registers, indexed 0 to 5. Registers 1 to 4 are shadowed. Each of them has a persistent copy, which stands in for nonvolatile storage, and a working copy. Only the working copies drive the configuration bus. Registers 0 and 5 have one copy each. Bit 7 of register 0 is the persist-mode bit. It decides whether a host write to a shadowed register also reaches the persistent copy or stays in the working copy only.

The working copies are refreshed from the persistent copies in two cases. The first is on the first clock after the power-on reset is released. The second is when an accepted write to register 0 or register 5 occurs while the persist-mode bit was clear before that write. A write-protect input, active low, blocks every write and therefore also blocks the refresh that a write would cause. Reads of the shadowed registers always return the persistent copy.

The persistent copies are plain flops. The power-on reset does not clear them. A separate initialisation input loads them with a parameterised default image.

Top module: `shadow_ctrl_bank`

## Requirements
- R1: While `porN` is low, `cfgBus`, `ctrl0`, `ctrl5` and `rdData` are zero. On the first rising clock edge after `porN` goes high, every working copy takes the value of its persistent copy.
- R2: A cycle with `nvInit` high loads the persistent copies with `NV_INIT`, where register k takes byte k-1. The working copies are left unchanged.
- R3: With bit 7 of register 0 set, an accepted write to index 1 to 4 updates both copies of that register at the same clock edge.
- R4: With bit 7 of register 0 clear, an accepted write to index 1 to 4 updates the working copy only. The persistent copy keeps its value.
- R5: A read registers its data at the edge where `rdEn` is high, and `rdData` holds that data until the next read. Index 1 to 4 returns the persistent copy, index 0 and index 5 return their single copy, and index 6 or 7 returns zero.
- R6: An accepted write to index 0 or index 5 refreshes all four working copies from the persistent copies at the same edge. This happens only if bit 7 of register 0 was clear before that write.
- R7: While `wpN` is low, writes to every index are ignored and cause no refresh. Reads still work.
- R8: Index k selects register k. The working copy of register k drives `cfgBus[8k-1:8k-8]`, so writes to indices 1, 2, 3 and 4 in that order fill the bus from its low byte upward.
- R9: A write to index 6 or index 7 changes no register and causes no refresh.
- R10: A power-on reset pulse clears the working copies, register 0 and register 5. It keeps the persistent copies, and the working copies then return to the persistent values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low and asynchronous. Clears the working state and triggers a refresh after release |
| nvInit | input | 1 | Loads the persistent copies with the default image |
| wpN | input | 1 | Write protect, active low |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| regIdx | input | 3 | Register index |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| cfgBus | output | 32 | Working copies of registers 1 to 4, with register 1 in the low byte |
| ctrl0 | output | 8 | Register 0; bit 7 is the persist-mode bit |
| ctrl5 | output | 8 | Register 5 |

## Verification
The assertions check four things on every cycle. Write protect suppresses every write and write-triggered refresh strobe. A persistent copy changes only on a persisting write or an init. A refresh leaves each untouched working copy equal to its persistent copy. A read of a shadowed index returns the persistent value.

Some behaviours show only in the bench's scenarios, which build histories where the two copies differ. One is that the refresh decision uses the old persist-mode value. Others are the byte ordering on the configuration bus, the holding of read data, and the survival of the persistent copies across a power-on reset pulse.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int SHADOW_CNT = 4;

  typedef struct packed {
    logic [SHADOW_CNT-1:0] wrVol;
    logic [SHADOW_CNT-1:0] wrNv;
    logic                  wrCtl0;
    logic                  wrCtl5;
    logic                  recall;
  } ctlStrobe_t;
endpackage

// File: rtl/shadow_ctl.sv
module shadow_ctl
  import shadow_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 3,
  parameter int MODE_BIT = 7
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              wpN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] modeReg,
  output ctlStrobe_t        strb
);
  localparam int LAST_IDX = SHADOW_CNT + 1;

  logic pwrRecall;
  logic accept;
  logic persistOn;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) pwrRecall <= 1'b1;
    else       pwrRecall <= 1'b0;
  end

  always_comb begin
    persistOn = modeReg[MODE_BIT];
    accept    = wrEn && wpN && (regIdx <= IDX_W'(LAST_IDX));
    for (int k = 0; k < SHADOW_CNT; k++) begin
      strb.wrVol[k] = accept && (regIdx == IDX_W'(k + 1));
      strb.wrNv[k]  = accept && (regIdx == IDX_W'(k + 1)) && persistOn;
    end
    strb.wrCtl0 = accept && (regIdx == '0);
    strb.wrCtl5 = accept && (regIdx == IDX_W'(LAST_IDX));
    strb.recall = pwrRecall || ((strb.wrCtl0 || strb.wrCtl5) && !persistOn);
  end

  assert_wp_blocks_write_R7: assert property (@(posedge clk) disable iff (!porN)
    !wpN |-> (strb.wrVol == '0 && strb.wrNv == '0 && !strb.wrCtl0 && !strb.wrCtl5));

  assert_wp_blocks_recall_R7: assert property (@(posedge clk) disable iff (!porN)
    (!wpN && !pwrRecall) |-> !strb.recall);

  assert_nv_needs_vol_R3: assert property (@(posedge clk) disable iff (!porN)
    ((strb.wrNv & ~strb.wrVol) == '0) && $onehot0(strb.wrVol));
endmodule

// File: rtl/shadow_store.sv
module shadow_store
  import shadow_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter logic [SHADOW_CNT*DATA_W-1:0] NV_INIT = '0
) (
  input  logic                         clk,
  input  logic                         porN,
  input  logic                         nvInit,
  input  ctlStrobe_t                   strb,
  input  logic [DATA_W-1:0]            wrData,
  input  logic                         rdEn,
  input  logic [IDX_W-1:0]             regIdx,
  output logic [SHADOW_CNT*DATA_W-1:0] cfgBus,
  output logic [DATA_W-1:0]            ctrl0,
  output logic [DATA_W-1:0]            ctrl5,
  output logic [DATA_W-1:0]            rdData
);
  localparam int LAST_IDX = SHADOW_CNT + 1;

  logic [DATA_W-1:0] volQ [SHADOW_CNT];
  logic [DATA_W-1:0] nvQ  [SHADOW_CNT];
  logic [DATA_W-1:0] rdNext;

  for (genvar k = 0; k < SHADOW_CNT; k++) begin : g_shadow
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)              volQ[k] <= '0;
      else if (strb.wrVol[k]) volQ[k] <= wrData;
      else if (strb.recall)   volQ[k] <= nvQ[k];
    end

    always_ff @(posedge clk) begin
      if (nvInit)            nvQ[k] <= NV_INIT[k*DATA_W +: DATA_W];
      else if (strb.wrNv[k]) nvQ[k] <= wrData;
    end

    assign cfgBus[k*DATA_W +: DATA_W] = volQ[k];

    assert_nv_hold_R4: assert property (@(posedge clk) disable iff (!porN)
      (!nvInit && !strb.wrNv[k]) |=> $stable(nvQ[k]));

    assert_recall_copy_R6: assert property (@(posedge clk) disable iff (!porN)
      (strb.recall && !strb.wrVol[k]) |=> (volQ[k] == $past(nvQ[k])));

    assert_read_nv_R5: assert property (@(posedge clk) disable iff (!porN)
      (rdEn && regIdx == IDX_W'(k + 1)) |=> (rdData == $past(nvQ[k])));
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      ctrl0 <= '0;
      ctrl5 <= '0;
    end else begin
      if (strb.wrCtl0) ctrl0 <= wrData;
      if (strb.wrCtl5) ctrl5 <= wrData;
    end
  end

  always_comb begin
    rdNext = '0;
    if (regIdx == '0) rdNext = ctrl0;
    else if (regIdx == IDX_W'(LAST_IDX)) rdNext = ctrl5;
    else begin
      for (int k = 0; k < SHADOW_CNT; k++)
        if (regIdx == IDX_W'(k + 1)) rdNext = nvQ[k];
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/shadow_ctrl_bank.sv
module shadow_ctrl_bank
  import shadow_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 3,
  parameter int MODE_BIT = 7,
  parameter logic [SHADOW_CNT*DATA_W-1:0] NV_INIT = 32'h4433_2211
) (
  input  logic                         clk,
  input  logic                         porN,
  input  logic                         nvInit,
  input  logic                         wpN,
  input  logic                         wrEn,
  input  logic                         rdEn,
  input  logic [IDX_W-1:0]             regIdx,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  output logic [SHADOW_CNT*DATA_W-1:0] cfgBus,
  output logic [DATA_W-1:0]            ctrl0,
  output logic [DATA_W-1:0]            ctrl5
);
  ctlStrobe_t strb;

  shadow_ctl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .MODE_BIT(MODE_BIT)) i_ctl (
    .clk(clk), .porN(porN), .wpN(wpN), .wrEn(wrEn), .regIdx(regIdx),
    .modeReg(ctrl0), .strb(strb)
  );

  shadow_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NV_INIT(NV_INIT)) i_store (
    .clk(clk), .porN(porN), .nvInit(nvInit), .strb(strb), .wrData(wrData),
    .rdEn(rdEn), .regIdx(regIdx), .cfgBus(cfgBus), .ctrl0(ctrl0),
    .ctrl5(ctrl5), .rdData(rdData)
  );
endmodule

// File: tb/test_shadow_ctrl_bank.sv
module test_shadow_ctrl_bank;
  localparam logic [31:0] DEF_IMG = 32'h4433_2211;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        nvInit = 1'b0;
  logic        wpN = 1'b1;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  regIdx = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [31:0] cfgBus;
  logic [7:0]  ctrl0;
  logic [7:0]  ctrl5;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  shadow_ctrl_bank #(.NV_INIT(DEF_IMG)) i_shadow_ctrl_bank (
    .clk(clk), .porN(porN), .nvInit(nvInit), .wpN(wpN), .wrEn(wrEn),
    .rdEn(rdEn), .regIdx(regIdx), .wrData(wrData), .rdData(rdData),
    .cfgBus(cfgBus), .ctrl0(ctrl0), .ctrl5(ctrl5)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regIdx = idx; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; regIdx = idx;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic t_power_up;
    nvInit = 1'b1;
    @(negedge clk);
    nvInit = 1'b0;
    check("R1 cfgBus in reset", cfgBus, 32'h0);
    check("R1 ctrl regs in reset", {ctrl0, ctrl5}, 32'h0);
    check("R1 rdData in reset", rdData, 32'h0);
    porN = 1'b1;
    @(negedge clk);
    check("R1 R2 recall at power-up", cfgBus, DEF_IMG);
  endtask

  task automatic t_volatile_fill;
    logic [7:0] d;
    wr(3'd1, 8'hA1); wr(3'd2, 8'hB2); wr(3'd3, 8'hC3); wr(3'd4, 8'hD4);
    check("R8 byte order on cfgBus", cfgBus, 32'hD4C3_B2A1);
    rd(3'd2, d);
    check("R4 R5 read keeps persistent copy", d, 8'h22);
  endtask

  task automatic t_recall_on_write;
    wr(3'd5, 8'h5A);
    check("R6 recall on register 5 write", cfgBus, DEF_IMG);
    check("R6 register 5 stored", ctrl5, 8'h5A);
    wr(3'd1, 8'hEE);
    check("R4 working-only write", cfgBus, 32'h4433_22EE);
    wr(3'd0, 8'h80);
    check("R6 recall uses old mode bit", cfgBus, DEF_IMG);
    check("R6 register 0 stored", ctrl0, 8'h80);
  endtask

  task automatic t_persist;
    logic [7:0] d;
    wr(3'd2, 8'h99);
    check("R3 persist write working copy", cfgBus, 32'h4433_9911);
    rd(3'd2, d);
    check("R3 persist write persistent copy", d, 8'h99);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'hAB);
    check("R4 mode cleared working write", cfgBus, 32'hAB33_9911);
  endtask

  task automatic t_protect;
    logic [7:0] d;
    wpN = 1'b0;
    wr(3'd5, 8'h12);
    check("R7 protected write register 5", ctrl5, 8'h5A);
    check("R7 no recall under protect", cfgBus, 32'hAB33_9911);
    wr(3'd1, 8'h55);
    check("R7 protected write register 1", cfgBus, 32'hAB33_9911);
    rd(3'd4, d);
    check("R7 read under protect", d, 8'h44);
    wpN = 1'b1;
  endtask

  task automatic t_out_of_range;
    logic [7:0] d;
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    check("R9 no change on index 6/7", cfgBus, 32'hAB33_9911);
    check("R9 ctrl regs unchanged", {ctrl0, ctrl5}, {16'h0, 8'h00, 8'h5A});
    rd(3'd6, d);
    check("R5 index 6 reads zero", d, 8'h00);
  endtask

  task automatic t_read_hold;
    logic [7:0] d;
    rd(3'd5, d);
    check("R5 read register 5", d, 8'h5A);
    wr(3'd3, 8'h3C);
    check("R5 rdData held", rdData, 8'h5A);
    check("R4 working write register 3", cfgBus, 32'hAB3C_9911);
  endtask

  task automatic t_nv_init;
    logic [7:0] d;
    @(negedge clk);
    nvInit = 1'b1;
    @(negedge clk);
    nvInit = 1'b0;
    check("R2 init leaves working copies", cfgBus, 32'hAB3C_9911);
    rd(3'd2, d);
    check("R2 init loads persistent copy", d, 8'h22);
    wr(3'd2, 8'h77);
    wr(3'd0, 8'h80);
    wr(3'd2, 8'h99);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_por_pulse;
    @(negedge clk);
    porN = 1'b0;
    #1;
    check("R10 reset clears working copies", cfgBus, 32'h0);
    check("R10 reset clears ctrl regs", {ctrl0, ctrl5}, 32'h0);
    @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    check("R10 R1 persistent copies survive reset", cfgBus, 32'h4433_9911);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_power_up();
    t_volatile_fill();
    t_recall_on_write();
    t_persist();
    t_protect();
    t_out_of_range();
    t_read_hold();
    t_nv_init();
    t_por_pulse();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule